// File: doc/BRIEF.md
# Digest-Bound PUF Response Selector

This block turns a 256-bit input digest into a 128-bit response that depends on both the digest and the silicon it runs on. The digest is split into a stream of 16-bit cell addresses inside a 65536-cell (8 KB) start-up memory region. Once the digest's own slices run out, a pseudo-random generator seeded from the digest supplies further addresses. For each candidate address the block reads a stability/reference memory that was written at enrolment. Cells marked unstable are passed over, as is any address already taken for the current response. For each remaining cell, the enrolled reference value becomes the next response bit.

A request is launched with a one-cycle `start_i` pulse while the block is idle. The response is built again from the memory on every request and is cleared at the start of each one, so nothing from an earlier request carries over. When 128 bits are collected, `done_o` pulses for one cycle and the response is held until the next start. The block gives up after 1024 candidates. In that case `fail_o` pulses and the partial response is wiped.

States and transitions: IDLE goes to PICK on `start_i`. PICK either reads the candidate from memory and goes to FETCH, or skips a repeated address and stays in PICK. When the 1024th candidate is a repeat, PICK goes to FAIL instead. FETCH takes the memory result and then goes to DONE (128th bit taken), to FAIL (candidate budget spent) or back to PICK. DONE and FAIL each last one cycle and return to IDLE.

Top module: `puf_resp_sel`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `mem_rd_o` are 0 and `resp_o` is all zeros.
- R2: Candidates 0 to 15 are the digest slices `digest_i[16*i+15:16*i]`, in ascending order of i.
- R3: From candidate 16 on, addresses come from a 16-bit right-shifting Galois LFSR. On each step the register shifts right by one and, if the bit shifted out was 1, is XORed with 0xB400. The seed is the XOR of the 16 digest slices, or 0xACE1 if that XOR is zero. Candidate 16 is the seed, and each later candidate is the next LFSR state.
- R4: Each candidate that is not a repeat raises `mem_rd_o` for exactly one cycle with the candidate on `mem_addr_o`. `mem_stable_i` and `mem_ref_i` are taken in the following cycle.
- R5: A candidate whose `mem_stable_i` is 0 adds no bit to the response.
- R6: A candidate equal to an address already selected in the current request is skipped without a memory read. The skip takes one cycle.
- R7: The reference value of the i-th selected cell is placed at `resp_o[i]`. `done_o` pulses for one cycle in the cycle after the 128th selection, and `resp_o` then holds until the next accepted start.
- R8: If 1024 candidates are used up without 128 selections, `fail_o` pulses for one cycle with `resp_o` cleared to zero, and `done_o` does not pulse. A selection on the 1024th candidate that completes the response counts as success.
- R9: An accepted start clears `resp_o` to zero in the next cycle. `start_i` has no effect while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a request (taken only when idle) |
| digest_i | input | 256 | Input digest, sampled at start |
| busy_o | output | 1 | Request in progress |
| mem_rd_o | output | 1 | Read strobe to the stability/reference memory |
| mem_addr_o | output | 16 | Cell address for the read |
| mem_stable_i | input | 1 | Cell is stable (1) or unstable (0), valid one cycle after the read |
| mem_ref_i | input | 1 | Enrolled reference value of the cell, valid with `mem_stable_i` |
| resp_o | output | 128 | Response, bit i is the i-th selected cell |
| done_o | output | 1 | One-cycle pulse: response complete |
| fail_o | output | 1 | One-cycle pulse: candidate budget exhausted |

## Verification
The hardest situations to reach from the ports are repeated addresses and an exhausted candidate budget. Neither occurs for a typical digest with a healthy memory. Repeats are forced with a digest whose 16 slices are all equal, and with an all-zero digest, which also drives the seed onto its fallback value. The bench memory in these cases marks every cell stable, so the first slice is certainly selected. Exhaustion is reached by switching the bench memory to a mode where every cell, or most cells, read as unstable. A start pulse sent in the middle of a request checks that a busy request ignores it.

// File: rtl/puf_sel_pkg.sv
package puf_sel_pkg;

    localparam int REGION_CELLS = 65536;
    localparam int CELL_ADDR_W  = $clog2(REGION_CELLS);

    localparam logic [CELL_ADDR_W-1:0] LFSR_TAPS     = 16'hB400;
    localparam logic [CELL_ADDR_W-1:0] SEED_FALLBACK = 16'hACE1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_FETCH,
        ST_DONE,
        ST_FAIL
    } sel_state_e;

    function automatic logic [CELL_ADDR_W-1:0] lfsr_step(input logic [CELL_ADDR_W-1:0] s);
        logic [CELL_ADDR_W-1:0] n;
        n = s >> 1;
        if (s[0]) begin
            n = n ^ LFSR_TAPS;
        end
        return n;
    endfunction

endpackage

// File: rtl/puf_addr_gen.sv
module puf_addr_gen
    import puf_sel_pkg::*;
#(
    parameter int DIGEST_W = 256,
    parameter int ADDR_W   = CELL_ADDR_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [DIGEST_W-1:0] digest_i,
    input  logic                step_i,
    output logic [ADDR_W-1:0]   cand_o
);

    localparam int NSLICE = DIGEST_W / ADDR_W;
    localparam int SEL_W  = $clog2(NSLICE);
    localparam int IDX_W  = $clog2(NSLICE + 1);
    localparam logic [IDX_W-1:0] NSLICE_L = IDX_W'(NSLICE);

    logic [ADDR_W-1:0] slice_q [NSLICE];
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] lfsr_q;
    logic [ADDR_W-1:0] fold;
    logic              in_slices;

    always_comb begin
        fold = '0;
        for (int i = 0; i < NSLICE; i++) begin
            fold = fold ^ digest_i[i*ADDR_W +: ADDR_W];
        end
    end

    assign in_slices = (idx_q < NSLICE_L);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q  <= '0;
            lfsr_q <= SEED_FALLBACK;
            for (int i = 0; i < NSLICE; i++) begin
                slice_q[i] <= '0;
            end
        end else if (load_i) begin
            idx_q  <= '0;
            lfsr_q <= (fold == '0) ? SEED_FALLBACK : fold;
            for (int i = 0; i < NSLICE; i++) begin
                slice_q[i] <= digest_i[i*ADDR_W +: ADDR_W];
            end
        end else if (step_i) begin
            if (in_slices) begin
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                lfsr_q <= lfsr_step(lfsr_q);
            end
        end
    end

    assign cand_o = in_slices ? slice_q[idx_q[SEL_W-1:0]] : lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0); // R3

    AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idx_q <= NSLICE_L); // R2

endmodule

// File: rtl/puf_used_table.sv
module puf_used_table
    import puf_sel_pkg::*;
#(
    parameter int ADDR_W = CELL_ADDR_W,
    parameter int DEPTH  = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [ADDR_W-1:0] add_addr_i,
    input  logic [ADDR_W-1:0] query_i,
    output logic              hit_o
);

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IX_W  = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(DEPTH);

    logic [ADDR_W-1:0] tab_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [DEPTH-1:0]  match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tab_q[g] == query_i);
    end

    assign hit_o = |match;

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            vld_q    <= '0;
            wr_ptr_q <= '0;
        end else if (add_i) begin
            tab_q[wr_ptr_q[IX_W-1:0]] <= add_addr_i;
            vld_q[wr_ptr_q[IX_W-1:0]] <= 1'b1;
            wr_ptr_q                  <= wr_ptr_q + PTR_W'(1);
        end
    end

    AST_TABLE_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        add_i |-> (wr_ptr_q < DEPTH_L)); // R7

    always @(posedge clk_i) begin
        if (rst_ni && add_i && !clear_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (vld_q[i]) begin
                    AST_NO_REPEAT_ADD: assert (tab_q[i] != add_addr_i); // R6
                end
            end
        end
    end

endmodule

// File: rtl/puf_resp_sel.sv
module puf_resp_sel
    import puf_sel_pkg::*;
#(
    parameter int DIGEST_W = 256,
    parameter int RESP_W   = 128,
    parameter int MAX_TRY  = 1024
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic [DIGEST_W-1:0]    digest_i,
    output logic                   busy_o,
    output logic                   mem_rd_o,
    output logic [CELL_ADDR_W-1:0] mem_addr_o,
    input  logic                   mem_stable_i,
    input  logic                   mem_ref_i,
    output logic [RESP_W-1:0]      resp_o,
    output logic                   done_o,
    output logic                   fail_o
);

    localparam int ADDR_W = CELL_ADDR_W;
    localparam int TRY_W  = $clog2(MAX_TRY + 1);
    localparam int CNT_W  = $clog2(RESP_W + 1);
    localparam int RIX_W  = $clog2(RESP_W);
    localparam logic [TRY_W-1:0] MAX_TRY_L = TRY_W'(MAX_TRY);
    localparam logic [CNT_W-1:0] LAST_L    = CNT_W'(RESP_W - 1);
    localparam logic [CNT_W-1:0] FULL_L    = CNT_W'(RESP_W);

    sel_state_e         state_q, state_d;
    logic [TRY_W-1:0]   tries_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [RESP_W-1:0]  resp_q;
    logic [ADDR_W-1:0]  fetch_addr_q;
    logic [ADDR_W-1:0]  cand;
    logic               dup_hit;
    logic               accept;
    logic               gen_step;
    logic               take_bit;
    logic               enter_fail;

    assign accept     = start_i && (state_q == ST_IDLE);
    assign enter_fail = (state_d == ST_FAIL) && (state_q != ST_FAIL);

    puf_addr_gen #(
        .DIGEST_W (DIGEST_W),
        .ADDR_W   (ADDR_W)
    ) addr_gen_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (accept),
        .digest_i (digest_i),
        .step_i   (gen_step),
        .cand_o   (cand)
    );

    puf_used_table #(
        .ADDR_W (ADDR_W),
        .DEPTH  (RESP_W)
    ) used_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (accept),
        .add_i      (take_bit),
        .add_addr_i (fetch_addr_q),
        .query_i    (cand),
        .hit_o      (dup_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_PICK;
            end
            ST_PICK: begin
                if (!dup_hit)                                state_d = ST_FETCH;
                else if ((tries_q + TRY_W'(1)) == MAX_TRY_L) state_d = ST_FAIL;
                else                                         state_d = ST_PICK;
            end
            ST_FETCH: begin
                if (mem_stable_i && (cnt_q == LAST_L)) state_d = ST_DONE;
                else if (tries_q == MAX_TRY_L)         state_d = ST_FAIL;
                else                                   state_d = ST_PICK;
            end
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // outputs and strobes
    always_comb begin
        busy_o   = 1'b0;
        mem_rd_o = 1'b0;
        done_o   = 1'b0;
        fail_o   = 1'b0;
        gen_step = 1'b0;
        take_bit = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PICK: begin
                busy_o   = 1'b1;
                gen_step = 1'b1;
                mem_rd_o = !dup_hit;
            end
            ST_FETCH: begin
                busy_o   = 1'b1;
                take_bit = mem_stable_i;
            end
            ST_DONE: done_o = 1'b1;
            ST_FAIL: fail_o = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr_o = cand;
    assign resp_o     = resp_q;

    // datapath registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tries_q      <= '0;
            cnt_q        <= '0;
            resp_q       <= '0;
            fetch_addr_q <= '0;
        end else if (accept) begin
            tries_q <= '0;
            cnt_q   <= '0;
            resp_q  <= '0;
        end else begin
            if (gen_step) begin
                tries_q      <= tries_q + TRY_W'(1);
                fetch_addr_q <= cand;
            end
            if (enter_fail) begin
                resp_q <= '0;
            end else if (take_bit) begin
                resp_q[cnt_q[RIX_W-1:0]] <= mem_ref_i;
            end
            if (take_bit) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && fail_o)); // R8
    AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_o |=> !mem_rd_o); // R4
    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && resp_o == $past(resp_o))); // R7
    AST_DONE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (cnt_q == FULL_L)); // R7
    AST_TRY_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tries_q <= MAX_TRY_L); // R8
    AST_FAIL_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> (resp_o == '0)); // R8
    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && !done_o && !fail_o) |=> (resp_o == '0 && busy_o)); // R9

endmodule

// File: tb/puf_resp_sel_tb.sv
module puf_resp_sel_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] digest = '0;
    logic         busy, mem_rd, done, fail;
    logic [15:0]  mem_addr;
    logic         mem_stable = 1'b0, mem_ref = 1'b0;
    logic [127:0] resp;

    int errors = 0;
    int checks = 0;
    int map_mode = 0;

    always #4 clk = ~clk;

    puf_resp_sel dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .digest_i     (digest),
        .busy_o       (busy),
        .mem_rd_o     (mem_rd),
        .mem_addr_o   (mem_addr),
        .mem_stable_i (mem_stable),
        .mem_ref_i    (mem_ref),
        .resp_o       (resp),
        .done_o       (done),
        .fail_o       (fail)
    );

    function automatic bit cell_stable(int a);
        int h;
        h = (a * 37 + (a >> 3) * 11) % 7;
        case (map_mode)
            1: return 1'b0;
            2: return (h == 0);
            3: return 1'b1;
            default: return (h != 0);
        endcase
    endfunction

    function automatic bit cell_ref(int a);
        if (map_mode == 3) return bit'((a ^ (a >> 7)) & 1);
        return bit'(((a >> 2) ^ a ^ (a >> 9)) & 1);
    endfunction

    // enrolled memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_stable <= cell_stable(int'(mem_addr));
            mem_ref    <= cell_ref(int'(mem_addr));
        end
    end

    // expected per-cycle trace
    bit           q_rd[$];
    int           q_addr[$];
    bit           q_busy[$];
    bit           q_done[$];
    bit           q_fail[$];
    logic [127:0] q_resp[$];
    logic [127:0] last_resp = '0;

    function automatic void push(bit rd, int addr, bit bz, bit dn, bit fl, logic [127:0] r);
        q_rd.push_back(rd);
        q_addr.push_back(addr);
        q_busy.push_back(bz);
        q_done.push_back(dn);
        q_fail.push_back(fl);
        q_resp.push_back(r);
    endfunction

    function automatic void build_model(logic [255:0] d);
        int used[$];
        int tries = 0;
        int cnt = 0;
        int k = 0;
        int s = 0;
        int cand;
        bit dup;
        logic [127:0] cur = '0;
        q_rd.delete(); q_addr.delete(); q_busy.delete();
        q_done.delete(); q_fail.delete(); q_resp.delete();
        for (int i = 0; i < 16; i++) s = s ^ int'(d[16*i +: 16]);
        if (s == 0) s = 'hACE1;
        forever begin
            if (k < 16) begin
                cand = int'(d[16*k +: 16]);
            end else begin
                cand = s;
                if ((s & 1) != 0) s = (s >> 1) ^ 'hB400;
                else              s = s >> 1;
            end
            k++;
            tries++;
            dup = 1'b0;
            foreach (used[j]) if (used[j] == cand) dup = 1'b1;
            if (dup) begin
                push(1'b0, 0, 1'b1, 1'b0, 1'b0, cur);
            end else begin
                push(1'b1, cand, 1'b1, 1'b0, 1'b0, cur);
                push(1'b0, 0, 1'b1, 1'b0, 1'b0, cur);
                if (cell_stable(cand)) begin
                    used.push_back(cand);
                    cur[cnt] = cell_ref(cand);
                    cnt++;
                    if (cnt == 128) begin
                        push(1'b0, 0, 1'b0, 1'b1, 1'b0, cur);
                        break;
                    end
                end
            end
            if (tries == 1024) begin
                cur = '0;
                push(1'b0, 0, 1'b0, 1'b0, 1'b1, cur);
                break;
            end
        end
        last_resp = cur;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_cycle(int k, string tag);
        chk(busy == q_busy[k], "R9", {tag, " busy"}, 128'(busy), 128'(q_busy[k]));
        chk(mem_rd == q_rd[k], "R4/R6", {tag, " mem_rd"}, 128'(mem_rd), 128'(q_rd[k]));
        if (q_rd[k])
            chk(int'(mem_addr) == q_addr[k], "R2/R3", {tag, " mem_addr"},
                128'(mem_addr), 128'(q_addr[k]));
        chk(done == q_done[k], "R7", {tag, " done"}, 128'(done), 128'(q_done[k]));
        chk(fail == q_fail[k], "R8", {tag, " fail"}, 128'(fail), 128'(q_fail[k]));
        chk(resp == q_resp[k], "R5/R7", {tag, " resp"}, resp, q_resp[k]);
    endtask

    task automatic run(logic [255:0] d, int mode, string tag, bit poke);
        int n;
        map_mode = mode;
        build_model(d);
        n = q_rd.size();
        @(negedge clk);
        digest = d;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        digest = '0;
        cmp_cycle(0, tag); // R9: resp cleared in the first cycle
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            if (poke && k == 4) start = 1'b1; // R9: ignored while busy
            if (poke && k == 5) start = 1'b0;
            cmp_cycle(k, tag);
        end
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_rd, "R7", {tag, " idle after end"},
            {busy, done, fail, mem_rd}, 128'(0));
        chk(resp == last_resp, "R7", {tag, " resp held"}, resp, last_resp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !fail && !mem_rd, "R1", "control outputs after reset",
            {busy, done, fail, mem_rd}, 128'(0));
        chk(resp == '0, "R1", "resp after reset", resp, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5: ordinary digest, mixed map, with a start pulse during the run (R9)
        run(256'h3C5A_91F0_0E7D_B246_7714_C0DE_5AA5_1F2E_8B39_D604_E1E1_2468_ACE0_0F0F_9999_4321,
            0, "r2_r5_r9 normal", 1'b1);
        // same digest again gives the same response (R9 start clears, regenerated)
        run(256'h3C5A_91F0_0E7D_B246_7714_C0DE_5AA5_1F2E_8B39_D604_E1E1_2468_ACE0_0F0F_9999_4321,
            0, "r9_repeat", 1'b0);
        // R6: every slice equal, all cells stable
        run({16{16'h1234}}, 3, "r6_equal_slices", 1'b0);
        // R3 fallback seed and R6 repeats on all-zero digest
        run('0, 3, "r3_zero_digest", 1'b0);
        // R8: all cells unstable
        run(256'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF_1111_2222_3333_4444_5555_6666_7777_8888,
            1, "r8_exhaust", 1'b0);
        // R5 R8: sparse stable cells
        run(256'h0BAD_F00D_CAFE_BEEF_DEAD_C0DE_1357_9BDF_2468_ACE0_F0E1_D2C3_B4A5_9687_7869_5A4B,
            2, "r5_r8_sparse", 1'b0);
        // completes normally after a failure
        run(256'h0001_0002_0003_0004_0005_0006_0007_0008_0009_000A_000B_000C_000D_000E_000F_0010,
            0, "r7_after_fail", 1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule